// File: doc/BRIEF.md
# Parallel Integer Tile Multiply-Accumulate Unit

The block forms one output tile C = A x B for each command it accepts. Every element of C has its own dot-product circuit, and all N x N elements are computed at the same time. Each circuit has a bank of multipliers that is registered once, then a pipelined binary adder tree. A bank of 32-bit accumulators follows the array. Each element is added either to a bias tile or to the value the accumulator already holds, so a long reduction can be split over several commands.

Two signed integer precisions are chosen per command. In wide mode the operands are 16-bit and the reduction depth is N. In narrow mode the operands are 8-bit and the depth is 2N: an N x 2N tile is multiplied by a 2N x N tile through the same operand port width. The command interface is a single-cycle `start` and a one-cycle `done` pulse. At the accepting edge the block captures the operand tiles, the bias tile and the mode bits. It holds its result on `c_tile` until the next write or clear. N must be a power of two and at least 2.

Top module: `mmu_tile_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `done` is 0 and every element of `c_tile` is 0.
- R2: With `narrow_mode`=0 and `accumulate_en`=0, element (r,c) becomes bias(r,c) + sum over k<N of A(r,k)*B(k,c), with signed 16-bit operands. A(r,k) is at `a_tile`[(r*N+k)*16 +: 16], B(k,c) is at `b_tile`[(c*N+k)*16 +: 16], bias and result (r,c) are at [(r*N+c)*32 +: 32].
- R3: With `narrow_mode`=1, the sum runs over k<2N with signed 8-bit operands. A(r,k) is at `a_tile`[(r*2N+k)*8 +: 8] and B(k,c) is at `b_tile`[(c*2N+k)*8 +: 8].
- R4: With `accumulate_en`=1, each element becomes its previous accumulator value plus the product sum, and `bias_tile` has no effect.
- R5: All sums and accumulations are taken modulo 2^32, with two's-complement wrap and no saturation.
- R6: If `start` is accepted at a clock edge, `done` is high for exactly one cycle, starting D+1 edges later, where D = log2(2N). `c_tile` takes the new result at that same edge.
- R7: A `start` that arrives while a command is in flight is ignored. It produces no extra `done` and does not change the result of the command in flight.
- R8: `clear` sampled high zeroes every accumulator. It takes priority over a result write at the same edge. Without `clear` or a write, `c_tile` holds its value.
- R9: Operands, bias and mode bits are sampled only at the accepting edge. Changing them afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command request, accepted when idle |
| narrow_mode | input | 1 | 1 = signed 8-bit with depth 2N, 0 = signed 16-bit with depth N |
| accumulate_en | input | 1 | 1 = add to previous C, 0 = add bias |
| clear | input | 1 | Zero all accumulators |
| a_tile | input | N*N*16 | Operand A, row order |
| b_tile | input | N*N*16 | Operand B, column order |
| bias_tile | input | N*N*32 | Bias per element, row order |
| done | output | 1 | One-cycle completion pulse |
| c_tile | output | N*N*32 | Accumulator contents, row order |

## Verification
The assertions assume that `start` is a request the block may drop. They also assume that `clear` may arrive at any edge, including the result-write edge, so the hold and clear properties are written to cover that case. The stimulus raises `start` only at the falling edge and keeps operands within range for the chosen mode. Right after acceptance it scrambles every input and raises `start` again while the command is busy, so R7 and R9 are exercised without breaking any assumption.

// File: rtl/mmu_pkg.sv
// Package: shared widths and the precision encoding of the tile multiplier.
// Assumes every user compiles this file first.
package mmu_pkg;
    localparam int WIDE_W   = 16;
    localparam int NARROW_W = 8;
    localparam int ACC_W    = 32;

    typedef enum logic {
        PREC_WIDE   = 1'b0,
        PREC_NARROW = 1'b1
    } prec_e;
endpackage

// File: rtl/mmu_ctrl.sv
// Module: command sequencer. Accepts start only when idle and walks a one-hot
// valid token through the product stage and DEPTH tree stages. Raises fire
// for the accumulate edge and then registers done.
// Assumes: DEPTH >= 1.
module mmu_ctrl #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic acc_en_in,
    output logic accept,
    output logic fire,
    output logic acc_en_q,
    output logic done
);
    logic [DEPTH:0] vld;
    logic           busy;

    assign busy   = |vld;
    assign accept = start && !busy;
    assign fire   = vld[DEPTH];

    // Advance the valid token and register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            done <= 1'b0;
        end else begin
            vld  <= {vld[DEPTH-1:0], accept};
            done <= fire;
        end
    end

    // Capture the accumulate selection of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_en_q <= 1'b0;
        else if (accept) acc_en_q <= acc_en_in;
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld));
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(acc_en_q) && !vld[0]));
endmodule

// File: rtl/mmu_tree.sv
// Module: pipelined binary adder tree. Each internal node is a register, so
// the root follows the leaves by log2(LEAVES) cycles. Free running; the
// caller holds the leaves steady and uses the root when its token arrives.
// Assumes: LEAVES is a power of two, at least 2. Sums wrap modulo 2^W.
module mmu_tree #(
    parameter int LEAVES = 8,
    parameter int W      = 32
) (
    input  logic                clk,
    input  logic [LEAVES*W-1:0] leaves,
    output logic [W-1:0]        root
);
    logic [W-1:0] node [1:LEAVES-1];

    for (genvar i = 1; i < LEAVES; i++) begin : g_node
        if (2 * i >= LEAVES) begin : g_edge
            // Add two leaves.
            always_ff @(posedge clk)
                node[i] <= leaves[(2*i-LEAVES)*W +: W] + leaves[(2*i+1-LEAVES)*W +: W];
        end else begin : g_inner
            // Add two child nodes.
            always_ff @(posedge clk)
                node[i] <= node[2*i] + node[2*i+1];
        end
    end

    assign root = node[1];
endmodule

// File: rtl/mmu_dot.sv
// Module: one output element. Picks 2N operand pairs from one A row and one
// B column according to the precision, multiplies them as 16x16 signed, and
// registers the products when load is high. In wide mode the upper N slots
// carry zero. The adder tree then reduces the products.
// Assumes: load lasts one cycle per command; row and column hold N*16 bits.
module mmu_dot
    import mmu_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  narrow,
    input  logic [N*WIDE_W-1:0]   a_row,
    input  logic [N*WIDE_W-1:0]   b_col,
    output logic [ACC_W-1:0]      sum
);
    localparam int K = 2 * N;

    logic [K*ACC_W-1:0] prod_flat;

    for (genvar k = 0; k < K; k++) begin : g_slot
        logic signed [WIDE_W-1:0] wa, wb, opa, opb;
        logic signed [ACC_W-1:0]  p;
        logic [NARROW_W-1:0]      na, nb;

        assign na = a_row[k*NARROW_W +: NARROW_W];
        assign nb = b_col[k*NARROW_W +: NARROW_W];

        if (k < N) begin : g_wide
            assign wa = a_row[k*WIDE_W +: WIDE_W];
            assign wb = b_col[k*WIDE_W +: WIDE_W];
        end else begin : g_pad
            assign wa = '0;
            assign wb = '0;
        end

        // Operand select: sign-extended narrow lane or wide lane.
        always_comb begin
            if (prec_e'(narrow) == PREC_NARROW) begin
                opa = {{(WIDE_W-NARROW_W){na[NARROW_W-1]}}, na};
                opb = {{(WIDE_W-NARROW_W){nb[NARROW_W-1]}}, nb};
            end else begin
                opa = wa;
                opb = wb;
            end
        end

        assign p = opa * opb;

        // Product register, loaded only when a command is accepted.
        always_ff @(posedge clk)
            if (load) prod_flat[k*ACC_W +: ACC_W] <= p;

        if (k >= N) begin : g_chk
            assert_wide_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (load && !narrow) |=> (prod_flat[k*ACC_W +: ACC_W] == '0));
        end
    end

    mmu_tree #(.LEAVES(K), .W(ACC_W)) tree_i (
        .clk    (clk),
        .leaves (prod_flat),
        .root   (sum)
    );
endmodule

// File: rtl/mmu_accbank.sv
// Module: accumulator bank after the array. Captures the bias tile when a
// command is accepted. On fire each element takes sum + bias or sum + its
// own value. Clear wins over fire. All arithmetic wraps modulo 2^32.
// Assumes: fire comes at most once per accepted command.
module mmu_accbank
    import mmu_pkg::*;
#(
    parameter int ELEMS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   fire,
    input  logic                   clear,
    input  logic                   acc_en,
    input  logic [ELEMS*ACC_W-1:0] bias_in,
    input  logic [ELEMS*ACC_W-1:0] sums,
    output logic [ELEMS*ACC_W-1:0] acc
);
    logic [ELEMS*ACC_W-1:0] bias_q;

    // Hold the bias of the accepted command.
    always_ff @(posedge clk)
        if (load) bias_q <= bias_in;

    for (genvar e = 0; e < ELEMS; e++) begin : g_acc
        logic [ACC_W-1:0] addend;

        assign addend = acc_en ? acc[e*ACC_W +: ACC_W] : bias_q[e*ACC_W +: ACC_W];

        // Accumulator element: reset, clear, write on fire, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) acc[e*ACC_W +: ACC_W] <= '0;
            else if (fire)       acc[e*ACC_W +: ACC_W] <= sums[e*ACC_W +: ACC_W] + addend;
        end
    end

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clear) |=> $stable(acc));
endmodule

// File: rtl/mmu_tile_top.sv
// Module: tile multiply-accumulate top. Slices the row-ordered A tile and the
// column-ordered B tile into N*N element circuits, sequences one command at a
// time and writes the accumulator bank.
// Assumes: N is a power of two, at least 2.
module mmu_tile_top
    import mmu_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    narrow_mode,
    input  logic                    accumulate_en,
    input  logic                    clear,
    input  logic [N*N*WIDE_W-1:0]   a_tile,
    input  logic [N*N*WIDE_W-1:0]   b_tile,
    input  logic [N*N*ACC_W-1:0]    bias_tile,
    output logic                    done,
    output logic [N*N*ACC_W-1:0]    c_tile
);
    localparam int DEPTH = $clog2(2 * N);
    localparam int LANE  = N * WIDE_W;

    logic                 accept, fire, acc_en_q;
    logic [N*N*ACC_W-1:0] sums;

    mmu_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .acc_en_in (accumulate_en),
        .accept    (accept),
        .fire      (fire),
        .acc_en_q  (acc_en_q),
        .done      (done)
    );

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            mmu_dot #(.N(N)) dot_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (accept),
                .narrow (narrow_mode),
                .a_row  (a_tile[r*LANE +: LANE]),
                .b_col  (b_tile[c*LANE +: LANE]),
                .sum    (sums[(r*N+c)*ACC_W +: ACC_W])
            );
        end
    end

    mmu_accbank #(.ELEMS(N*N)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .fire    (fire),
        .clear   (clear),
        .acc_en  (acc_en_q),
        .bias_in (bias_tile),
        .sums    (sums),
        .acc     (c_tile)
    );
endmodule

// File: tb/mmu_tile_top_tb.sv
module mmu_tile_top_tb_top;
    localparam int N = 4;
    localparam int K2 = 2 * N;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, narrow_mode = 1'b0, accumulate_en = 1'b0, clear = 1'b0;
    logic [N*N*16-1:0] a_tile = '0, b_tile = '0;
    logic [N*N*32-1:0] bias_tile = '0;
    logic done;
    logic [N*N*32-1:0] c_tile;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    int am [N][K2];
    int bm [K2][N];
    int biasm [N*N];
    int accm [N*N];
    logic [31:0] lf = 32'h1234_5678;

    always #10 clk = ~clk;

    mmu_tile_top #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .narrow_mode(narrow_mode),
        .accumulate_en(accumulate_en), .clear(clear), .a_tile(a_tile),
        .b_tile(b_tile), .bias_tile(bias_tile), .done(done), .c_tile(c_tile)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    task automatic fill_rand(input bit nar);
        for (int r = 0; r < N; r++)
            for (int k = 0; k < K2; k++) begin
                logic [31:0] x = rnd();
                logic [31:0] y = rnd();
                am[r][k] = nar ? int'($signed(x[7:0])) : int'($signed(x[15:0]));
                bm[k][r] = nar ? int'($signed(y[7:0])) : int'($signed(y[15:0]));
            end
        for (int e = 0; e < N*N; e++) biasm[e] = int'(rnd());
    endtask

    task automatic fill_const(input int va, input int vb, input int vbias);
        for (int r = 0; r < N; r++)
            for (int k = 0; k < K2; k++) begin
                am[r][k] = va;
                bm[k][r] = vb;
            end
        for (int e = 0; e < N*N; e++) biasm[e] = vbias;
    endtask

    task automatic drive(input bit nar);
        a_tile = '0;
        b_tile = '0;
        for (int r = 0; r < N; r++)
            for (int k = 0; k < K2; k++) begin
                if (nar) begin
                    a_tile[(r*K2+k)*8 +: 8] = am[r][k][7:0];
                    b_tile[(r*K2+k)*8 +: 8] = bm[k][r][7:0];
                end else if (k < N) begin
                    a_tile[(r*N+k)*16 +: 16] = am[r][k][15:0];
                    b_tile[(r*N+k)*16 +: 16] = bm[k][r][15:0];
                end
            end
        for (int e = 0; e < N*N; e++) bias_tile[e*32 +: 32] = biasm[e];
    endtask

    task automatic run_cmd(input bit nar, input bit acc, input bit clr_fire,
                           input bit poke, input string tag);
        int depth = nar ? K2 : N;
        @(negedge clk);
        drive(nar);
        narrow_mode = nar;
        accumulate_en = acc;
        start = 1'b1;
        @(negedge clk);
        // Accepted; scramble everything (R9) and optionally request again while busy (R7).
        start = poke;
        a_tile = ~a_tile ^ {(N*N/2){32'h5a5a_0f0f}};
        b_tile = {b_tile[N*N*16-2:0], 1'b1};
        bias_tile = ~bias_tile;
        narrow_mode = ~nar;
        accumulate_en = ~acc;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                int s = 0;
                for (int k = 0; k < depth; k++) s += am[r][k] * bm[k][c];
                if (clr_fire) accm[r*N+c] = 0;
                else accm[r*N+c] = s + (acc ? accm[r*N+c] : biasm[r*N+c]);
            end
        chk({31'd0, done}, 32'd0, "R6 done early");
        for (int j = 1; j <= D; j++) begin
            @(negedge clk);
            start = 1'b0;
            chk({31'd0, done}, 32'd0, "R6 done early");
        end
        clear = clr_fire;
        @(negedge clk);
        clear = 1'b0;
        chk({31'd0, done}, 32'd1, "R6 done at latency");
        for (int e = 0; e < N*N; e++)
            chk(c_tile[e*32 +: 32], accm[e], $sformatf("%s/R9 element %0d", tag, e));
        @(negedge clk);
        chk({31'd0, done}, 32'd0, "R6 done one cycle");
        if (poke)
            for (int j = 0; j < D + 2; j++) begin
                @(negedge clk);
                chk({31'd0, done}, 32'd0, "R7 no extra done");
            end
        for (int e = 0; e < N*N; e++)
            chk(c_tile[e*32 +: 32], accm[e], $sformatf("R8 hold element %0d", e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < N*N; e++) accm[e] = 0;
        repeat (3) @(negedge clk);
        chk({31'd0, done}, 32'd0, "R1 done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({31'd0, done}, 32'd0, "R1 done after reset");
        for (int e = 0; e < N*N; e++) chk(c_tile[e*32 +: 32], 32'd0, "R1 c_tile after reset");

        // R2: wide mode, random signed 16-bit operands.
        for (int t = 0; t < 12; t++) begin fill_rand(0); run_cmd(0, 0, 0, 0, "R2"); end
        // R3: narrow mode, random signed 8-bit operands, depth 2N.
        for (int t = 0; t < 12; t++) begin fill_rand(1); run_cmd(1, 0, 0, 0, "R3"); end
        // R3: near-exhaustive sweep of every 8-bit value.
        for (int v = -128; v < 128; v++) begin
            logic [31:0] w = v * 37 + 11;
            fill_const(v, int'($signed(w[7:0])), v * 1000);
            run_cmd(1, 0, 0, 0, "R3 sweep");
        end
        // R4: accumulate chains, bias must have no effect.
        for (int t = 0; t < 6; t++) begin fill_rand(t % 2); run_cmd(t % 2, 1, 0, 0, "R4"); end
        // R5: extreme wide values and wrap through repeated accumulation.
        fill_const(-32768, -32768, 32'h7fff_ffff); run_cmd(0, 0, 0, 0, "R5");
        fill_const(-32768, 32767, 5);
        for (int t = 0; t < 5; t++) run_cmd(0, 1, 0, 0, "R5 wrap");
        fill_const(32767, 32767, -1);
        for (int t = 0; t < 5; t++) run_cmd(0, 1, 0, 0, "R5 wrap pos");
        fill_const(-128, -128, 32'h8000_0000); run_cmd(1, 0, 0, 0, "R5 narrow");
        // R7: start raised while busy must be ignored.
        for (int t = 0; t < 4; t++) begin fill_rand(t % 2); run_cmd(t % 2, t / 2, 0, 1, "R7"); end
        // R8: clear while idle.
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int e = 0; e < N*N; e++) begin
            accm[e] = 0;
            chk(c_tile[e*32 +: 32], 32'd0, "R8 clear idle");
        end
        // R4 after clear: accumulate starts from zero.
        fill_rand(0); run_cmd(0, 1, 0, 0, "R4 from zero");
        // R8: clear at the write edge wins.
        fill_rand(1); run_cmd(1, 0, 1, 0, "R8 clear priority");
        fill_rand(0); run_cmd(0, 0, 0, 0, "R2 after clear");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule